// File: doc/BRIEF.md
# Sync-Locked Convolutional Byte Deinterleaver

The block takes a byte stream from a cable demodulator, qualified by a valid strobe, and recovers the packet structure before any byte is reordered. Packets are 204 bytes long. While hunting, the block waits for a sync byte. It then checks that further sync bytes keep arriving exactly one packet apart. Either the plain sync value or its bit-inverted form counts as a sync. Once a configured number of consecutive packet starts have carried a sync, the block declares lock.

After lock, every accepted byte passes through a 12-branch convolutional deinterleaver. The branches share one RAM, and each branch owns a circular region of its own. Branch j holds (11-j)×17 cells, so branch 11 is a straight wire. The branch selector is forced back to branch 0 on every packet-start sync. The block then waits out a fill period of 2244 accepted bytes, which is long enough for the RAM to hold only post-lock data. After that it enters tracking and presents deinterleaved bytes with a packet-start flag to a downstream Reed-Solomon decoder. If a configured number of consecutive packet starts lack a sync while locked, the block drops back to hunting.

Top module: `sync_deinterleaver`

## Requirements
- R1: Feed the block a stream built by the complementary interleaver, in which branch j = (byte index mod 12) delays by j×17 cells. Once tracking, the block outputs the original stream: the byte accepted at stream index i comes out as original byte i−2244.
- R2: Both 0x47 and 0xB8 at a packet start count as a valid sync, whether hunting, confirming or tracking.
- R3: `out_lock` rises on the cycle after the block accepts the sync byte that completes `cfg_lock_cnt` consecutive syncs spaced 204 accepted bytes apart. A count of 0 acts as 1.
- R4: While confirming, a packet start without a sync returns the block to hunting, and the sync count starts again from the next sync byte.
- R5: `out_valid` stays low through the fill period. The first valid output belongs to the byte accepted 2244 bytes after the locking sync byte.
- R6: Each accepted byte produces its output one clock later. A cycle with `in_valid` low produces `out_valid` low and changes no internal position or state.
- R7: `out_sop` is high, together with `out_valid`, exactly on the first byte of each deinterleaved packet, which is the sync byte.
- R8: While locked, `cfg_loss_cnt` consecutive packet starts without a sync (0 acts as 1) return the block to hunting. The last such byte is still output, after which `out_lock` and `out_valid` are low. A good sync clears the miss count.
- R9: After reset, `out_valid`, `out_sop` and `out_lock` are low and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte from demodulator |
| cfg_lock_cnt | input | 4 | Consecutive syncs needed for lock |
| cfg_loss_cnt | input | 4 | Consecutive missing syncs that drop lock |
| out_valid | output | 1 | Deinterleaved byte strobe |
| out_data | output | 8 | Deinterleaved byte |
| out_sop | output | 1 | First byte of a deinterleaved packet |
| out_lock | output | 1 | Packet alignment held (fill or tracking) |

## Verification
The bench drives streams made by its own interleaver model and compares every output byte against the original stream. A wrong branch base, depth or pointer wrap would corrupt the data at a fixed period. The bench aims at the exact byte where output starts after fill: an off-by-one fill counter would emit one garbage byte or lose the first sync byte.

It breaks a sync during confirmation, which catches a block that locks on non-consecutive syncs. It inserts a single missed sync between good ones during tracking, which catches a miss counter that is never cleared. Idle gaps in the valid strobe expose any counter that advances without data. A stream with an inverted sync on the first packet shows whether 0xB8 is rejected, because the lock index then moves.

// File: rtl/dil_pkg.sv
package dil_pkg;

  localparam logic [7:0] SYNC_WORD     = 8'h47;
  localparam logic [7:0] SYNC_WORD_INV = 8'hB8;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_FILL   = 2'd2,
    ST_TRACK  = 2'd3
  } dil_state_e;

  // Number of RAM cells owned by branch b.
  function automatic int branch_depth(int nb, int unit, int b);
    return (nb - 1 - b) * unit;
  endfunction

  // First RAM cell of branch b: branches are packed one after another.
  function automatic int branch_base(int nb, int unit, int b);
    int sum;
    sum = 0;
    for (int k = 0; k < b; k++) sum += branch_depth(nb, unit, k);
    return sum;
  endfunction

  // Commutator position of a byte at in-packet offset pos.
  function automatic int branch_of(int pos, int nb);
    return pos % nb;
  endfunction

  // Total end-to-end delay in bytes through interleaver + deinterleaver.
  function automatic int total_latency(int nb, int unit);
    return nb * unit * (nb - 1);
  endfunction

endpackage

// File: rtl/dil_sync_fsm.sv
module dil_sync_fsm
  import dil_pkg::*;
#(
  parameter int NB  = 12,
  parameter int UNIT = 17,
  parameter int CW  = 4,
  localparam int PKT = NB * UNIT,
  localparam int PW  = $clog2(PKT),
  localparam int FILL_LEN = NB * UNIT * (NB - 1),
  localparam int FW  = $clog2(FILL_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic [CW-1:0] cfg_lock_cnt,
  input  logic [CW-1:0] cfg_loss_cnt,
  output logic [PW-1:0] cur_pos,
  output logic          locked,
  output logic          tracking
);

  dil_state_e    state_q;
  logic [PW-1:0] pos_q;
  logic [CW-1:0] cnt_q, miss_q;
  logic [FW-1:0] fcnt_q;

  logic          sync_hit, at_start;
  logic [CW:0]   lock_tgt, loss_tgt;
  logic          ev_acq, ev_lock, ev_verify_fail, ev_miss, ev_loss, ev_fill_done;

  always_comb begin
    sync_hit = (in_data == SYNC_WORD) || (in_data == SYNC_WORD_INV);
    lock_tgt = (cfg_lock_cnt == '0) ? (CW+1)'(1) : {1'b0, cfg_lock_cnt};
    loss_tgt = (cfg_loss_cnt == '0) ? (CW+1)'(1) : {1'b0, cfg_loss_cnt};
    cur_pos  = (state_q == ST_SEARCH && sync_hit) ? '0 : pos_q;
    locked   = (state_q == ST_FILL) || (state_q == ST_TRACK);
    tracking = (state_q == ST_TRACK);
    at_start = in_valid && (cur_pos == '0);
  end

  // Named internal events.
  always_comb begin
    ev_acq         = in_valid && (state_q == ST_SEARCH) && sync_hit;
    ev_lock        = (ev_acq && lock_tgt == (CW+1)'(1)) ||
                     ((state_q == ST_VERIFY) && at_start && sync_hit &&
                      ({1'b0, cnt_q} + (CW+1)'(1) >= lock_tgt));
    ev_verify_fail = (state_q == ST_VERIFY) && at_start && !sync_hit;
    ev_miss        = locked && at_start && !sync_hit;
    ev_loss        = ev_miss && ({1'b0, miss_q} + (CW+1)'(1) >= loss_tgt);
    ev_fill_done   = (state_q == ST_FILL) && in_valid &&
                     (fcnt_q == FW'(FILL_LEN - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      pos_q   <= '0;
      cnt_q   <= '0;
      miss_q  <= '0;
      fcnt_q  <= '0;
    end else if (in_valid) begin
      pos_q <= (cur_pos == PW'(PKT - 1)) ? '0 : cur_pos + PW'(1);
      if (ev_loss) begin
        state_q <= ST_SEARCH;
        miss_q  <= '0;
        cnt_q   <= '0;
      end else if (ev_lock) begin
        state_q <= ST_FILL;
        fcnt_q  <= FW'(1);
        miss_q  <= '0;
      end else if (ev_acq) begin
        state_q <= ST_VERIFY;
        cnt_q   <= CW'(1);
      end else if (ev_verify_fail) begin
        state_q <= ST_SEARCH;
        cnt_q   <= '0;
      end else begin
        if ((state_q == ST_VERIFY) && at_start && sync_hit) cnt_q <= cnt_q + CW'(1);
        if (ev_miss) miss_q <= miss_q + CW'(1);
        else if (locked && at_start) miss_q <= '0;
        if (state_q == ST_FILL) fcnt_q <= fcnt_q + FW'(1);
        if (ev_fill_done) state_q <= ST_TRACK;
      end
    end
  end

  assert_fill_precedes_track_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tracking) |-> $past(state_q) == ST_FILL);

  assert_lock_on_sync_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_valid && sync_hit));

  assert_stall_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos_q) && $stable(state_q));

  assert_loss_drops_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    ev_loss |=> !locked);

  assert_verify_fail_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    ev_verify_fail |=> (state_q == ST_SEARCH));

endmodule

// File: rtl/dil_branch_ram.sv
module dil_branch_ram
  import dil_pkg::*;
#(
  parameter int NB   = 12,
  parameter int UNIT = 17,
  parameter int DW   = 8,
  localparam int CELLS = UNIT * NB * (NB - 1) / 2,
  localparam int AW  = $clog2(CELLS),
  localparam int PTW = $clog2((NB - 1) * UNIT),
  localparam int BW  = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [BW-1:0] branch,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0]  mem [CELLS];
  logic [PTW-1:0] ptr_q [NB-1];
  logic [AW-1:0]  addr;
  logic           has_cells;

  // One circular pointer per delayed branch.
  for (genvar j = 0; j < NB - 1; j++) begin : g_ptr
    localparam int DEPTH = branch_depth(NB, UNIT, j);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[j] <= '0;
      else if (in_valid && branch == BW'(j))
        ptr_q[j] <= (ptr_q[j] == PTW'(DEPTH - 1)) ? '0 : ptr_q[j] + PTW'(1);
    end

    assert_ptr_range_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q[j] < PTW'(DEPTH));
  end

  always_comb begin
    addr = '0;
    for (int j = 0; j < NB - 1; j++)
      if (branch == BW'(j)) addr = AW'(branch_base(NB, UNIT, j)) + AW'(ptr_q[j]);
    has_cells = (branch != BW'(NB - 1));
    rd_data   = mem[addr];
  end

  // Read-before-write: the oldest cell is read and refilled in one cycle.
  always_ff @(posedge clk) begin
    if (in_valid && has_cells) mem[addr] <= in_data;
  end

endmodule

// File: rtl/sync_deinterleaver.sv
module sync_deinterleaver
  import dil_pkg::*;
#(
  parameter int NB   = 12,
  parameter int UNIT = 17,
  parameter int CW   = 4,
  localparam int PKT = NB * UNIT,
  localparam int PW  = $clog2(PKT),
  localparam int BW  = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic [CW-1:0] cfg_lock_cnt,
  input  logic [CW-1:0] cfg_loss_cnt,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_sop,
  output logic          out_lock
);

  logic [PW-1:0] cur_pos;
  logic          locked, tracking;
  logic [BW-1:0] branch;
  logic [7:0]    rd_data;

  dil_sync_fsm #(.NB(NB), .UNIT(UNIT), .CW(CW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .cfg_lock_cnt (cfg_lock_cnt),
    .cfg_loss_cnt (cfg_loss_cnt),
    .cur_pos      (cur_pos),
    .locked       (locked),
    .tracking     (tracking)
  );

  assign branch = BW'(branch_of(int'(cur_pos), NB));

  dil_branch_ram #(.NB(NB), .UNIT(UNIT), .DW(8)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .branch   (branch),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else if (in_valid) begin
      out_valid <= tracking;
      out_sop   <= tracking && (cur_pos == '0);
      out_data  <= (branch == BW'(NB - 1)) ? in_data : rd_data;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
    end
  end

  assign out_lock = locked;

  assert_idle_out_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_sop_with_valid_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);

endmodule

// File: tb/test_sync_deinterleaver.sv
module test_sync_deinterleaver;

  localparam int PKT  = 204;
  localparam int LAT  = 2244;
  localparam int NONE = 1 << 30;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic [3:0] cfg_lock_cnt, cfg_loss_cnt;
  logic       out_valid, out_sop, out_lock;
  logic [7:0] out_data;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sync_deinterleaver i_sync_deinterleaver (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .cfg_lock_cnt (cfg_lock_cnt),
    .cfg_loss_cnt (cfg_loss_cnt),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_sop      (out_sop),
    .out_lock     (out_lock)
  );

  // Original (pre-interleave) stream; every 8th packet carries the inverted sync.
  function automatic logic [7:0] orig(int n);
    logic [7:0] v;
    if (n < 0) return 8'h00;
    if (n % PKT == 0) return ((n / PKT) % 8 == 0) ? 8'hB8 : 8'h47;
    v = 8'((n * 37 + (n / PKT) * 11 + 5) & 255);
    if (v == 8'h47 || v == 8'hB8) v = v ^ 8'h01;
    return v;
  endfunction

  // Interleaver model: branch j = i mod 12 delays by j*17 cells of 12 bytes.
  function automatic logic [7:0] tx(int i);
    return orig(i - PKT * (i % 12));
  endfunction

  function automatic logic [7:0] stream_byte(int i, int bad_one, int bad_from);
    if (i % PKT == 0 && (i == bad_one || i >= bad_from)) return 8'h00;
    return tx(i);
  endfunction

  task automatic chk(string req, string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s]: actual=%0h expected=%0h", req, tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_byte(bit pv, int idx, int s, int l, string tag);
    bit ev, el;
    if (!pv) begin
      chk("R6", {tag, " idle cycle"}, int'(out_valid), 0);
      return;
    end
    if (idx < 0) begin
      chk("R3", {tag, " junk lock"}, int'(out_lock), 0);
      chk("R5", {tag, " junk valid"}, int'(out_valid), 0);
      return;
    end
    ev = (idx >= s + LAT) && (idx <= l);
    el = (idx >= s) && (idx < l);
    chk((idx >= l) ? "R8" : "R5", $sformatf("%s valid idx %0d", tag, idx), int'(out_valid), int'(ev));
    chk((idx >= l) ? "R8" : "R3", $sformatf("%s lock idx %0d", tag, idx), int'(out_lock), int'(el));
    if (ev) begin
      chk("R1", $sformatf("%s data idx %0d", tag, idx), int'(out_data), int'(orig(idx - LAT)));
      chk("R7", $sformatf("%s sop idx %0d", tag, idx), int'(out_sop), int'(idx % PKT == 0));
    end
  endtask

  task automatic run_stream(int lock_cfg, int loss_cfg, int junk, int gap,
                            int bad_one, int bad_from, int s, int l,
                            int nbytes, string tag);
    int  sent, cyc, pidx;
    bit  pvalid, have_prev;
    cfg_lock_cnt = 4'(lock_cfg);
    cfg_loss_cnt = 4'(loss_cfg);
    do_reset();
    sent = 0; cyc = 0; have_prev = 1'b0; pvalid = 1'b0; pidx = 0;
    while (sent < junk + nbytes) begin
      @(negedge clk);
      if (have_prev) check_byte(pvalid, pidx, s, l, tag);
      if (gap != 0 && cyc % gap == gap - 1) begin
        in_valid = 1'b0;
        pvalid   = 1'b0;
      end else begin
        pidx     = sent - junk;
        in_valid = 1'b1;
        in_data  = (pidx < 0) ? 8'h11 : stream_byte(pidx, bad_one, bad_from);
        pvalid   = 1'b1;
        sent++;
      end
      have_prev = 1'b1;
      cyc++;
    end
    @(negedge clk);
    check_byte(pvalid, pidx, s, l, tag);
    in_valid = 1'b0;
  endtask

  // R9: reset state.
  task automatic t_reset();
    cfg_lock_cnt = 4'd3;
    cfg_loss_cnt = 4'd2;
    do_reset();
    chk("R9", "reset valid", int'(out_valid), 0);
    chk("R9", "reset sop",   int'(out_sop), 0);
    chk("R9", "reset lock",  int'(out_lock), 0);
  endtask

  // R1 R2 R3 R5 R7: three syncs (first inverted) after junk bytes.
  task automatic t_lock_three();
    run_stream(3, 2, 5, 0, NONE, NONE, 408, NONE, 408 + LAT + 3 * PKT, "R2 lock3");
  endtask

  // R3 R6 R2: count 0 acts as 1, gaps in valid, loss count 1 so a rejected 0xB8 would drop lock.
  task automatic t_gaps_single();
    run_stream(0, 1, 0, 7, NONE, NONE, 0, NONE, LAT + 1100, "R2 R6 gaps");
  endtask

  // R4: a broken sync during confirmation restarts the count.
  task automatic t_verify_break();
    run_stream(3, 2, 0, 0, PKT, NONE, 816, NONE, 816 + LAT + 300, "R4 break");
  endtask

  // R8: single miss cleared by good sync, then two misses drop lock.
  task automatic t_loss();
    run_stream(2, 2, 0, 0, 2856, 3264, 204, 3468, 3468 + 60, "R8 loss");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    cfg_lock_cnt = 4'd1; cfg_loss_cnt = 4'd1;
    t_reset();
    t_lock_three();
    t_gaps_single();
    t_verify_break();
    t_loss();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule